// File: doc/BRIEF.md
# Amplitude-Binned Time-Walk Corrector

This block corrects the time-walk of a timing measurement. The timing value is skewed by the size of the pulse it came from, so the block uses the paired 12-bit amplitude of the same sample. The amplitude is sorted into one of eight bins, each with its own programmable upper limit. The signed offset belonging to that bin is then added to the 12-bit timing value. Each of 32 channels has its own eight limits and eight offsets.

Samples arrive as a stream. Each carries a valid strobe, a 5-bit channel tag, the amplitude and the timing value. They leave two cycles later in the same form. The input is expected to be data whose pedestal has already been removed. The output is meant to feed a downstream channel-mask stage. Only timing channels are corrected, meaning channels whose index has bit 2 set. Every other channel passes through untouched.

Limits and offsets are loaded one at a time through a write port. The port is addressed by channel, bin and a select bit. After reset every channel is a pass-through: all limits are at full scale and all offsets are zero.

Top module: `slew_corrector`

## Requirements
- R1: After reset, `out_valid` is 0. Every limit reads 4095 and every offset reads 0, so each sample leaves with `out_tac` equal to its `in_tac`.
- R2: A sample presented with `in_valid` high appears with `out_valid` high exactly two cycles later, with its channel and amplitude unchanged. A cycle without `in_valid` gives a cycle without `out_valid` two cycles later. Samples may arrive back to back.
- R3: An amplitude selects bin N (0..7) when it is greater than limit N-1 and at most limit N. Bin 0 has an implied lower bound of zero, so an amplitude of 0 always selects bin 0.
- R4: When several limits are equal, the lowest-indexed bin that meets the rule of R3 is taken.
- R5: The offset is applied only when bit 2 of the channel index is 1 (channels 4-7, 12-15, 20-23, 28-31). On every other channel, `out_tac` equals `in_tac` whatever is stored for that channel.
- R6: The corrected value is `in_tac` plus the bin's offset. A result below 0 is clamped to 0, and a result above 4095 is clamped to 4095; it never wraps.
- R7: A write with `cfg_we` high stores `cfg_data[11:0]` as a limit when `cfg_sel` is 0. When `cfg_sel` is 1 it stores `cfg_data[8:0]` as a two's-complement offset (-256..255). The entry written is the one for `cfg_chan` and `cfg_bin`. The new value applies to samples presented from the next cycle on. A sample presented in the same cycle as the write still uses the old value.
- R8: An amplitude greater than all eight limits selects bin 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 5 | Input channel tag |
| in_adc | input | 12 | Input amplitude |
| in_tac | input | 12 | Input timing value (pedestal removed) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 5 | Channel addressed by the write |
| cfg_bin | input | 3 | Bin addressed by the write |
| cfg_sel | input | 1 | 0 = limit, 1 = offset |
| cfg_data | input | 12 | Write data (limit in [11:0], offset in [8:0]) |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 5 | Output channel tag |
| out_adc | output | 12 | Amplitude passed through |
| out_tac | output | 12 | Corrected timing value |

## Verification
Every result is due two clock edges after the sample is driven, and this holds for corrected channels and bypassed channels alike. The bench drives on falling edges and carries the expected result of each sample through a two-entry shadow pipeline. It checks the output at the falling edge two drives later, so every one of the back-to-back samples is checked in its own cycle. A configuration write becomes visible one edge after it is driven. The bench therefore computes each sample's expected value before applying any write made in the same cycle to its model, which checks that a sample presented alongside the write still sees the old value.

// File: rtl/slew_pkg.sv
// Package: slew_pkg
// Shared sizes and types for the amplitude-binned time-walk corrector.
// Assumes a power-of-two bin count and channel count.
package slew_pkg;
    localparam int unsigned ADC_W      = 12;
    localparam int unsigned TAC_W      = 12;
    localparam int unsigned OFF_W      = 9;
    localparam int unsigned N_BINS     = 8;
    localparam int unsigned N_CHAN     = 32;
    localparam int unsigned TIMING_BIT = 2;
    localparam int unsigned BIN_W      = $clog2(N_BINS);
    localparam int unsigned CH_W       = $clog2(N_CHAN);
    localparam int unsigned CFG_W      = (ADC_W > OFF_W) ? ADC_W : OFF_W;

    typedef enum logic {
        CFG_LIMIT  = 1'b0,
        CFG_OFFSET = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/slew_cfg_store.sv
// Module: slew_cfg_store
// Holds eight limits and eight signed offsets for each channel. Presents
// the full set of one channel combinationally to the bin search. Reset
// loads full-scale limits and zero offsets, so every channel starts as a
// pass-through. Assumes one write per cycle at most.
module slew_cfg_store
    import slew_pkg::*;
#(
    parameter int unsigned P_ADC_W  = ADC_W,
    parameter int unsigned P_OFF_W  = OFF_W,
    parameter int unsigned P_N_BINS = N_BINS,
    parameter int unsigned P_N_CHAN = N_CHAN,
    localparam int unsigned L_BIN_W = $clog2(P_N_BINS),
    localparam int unsigned L_CH_W  = $clog2(P_N_CHAN),
    localparam int unsigned L_CFG_W = (P_ADC_W > P_OFF_W) ? P_ADC_W : P_OFF_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [L_CH_W-1:0]                  wr_chan,
    input  logic [L_BIN_W-1:0]                 wr_bin,
    input  logic                               wr_sel,
    input  logic [L_CFG_W-1:0]                 wr_data,
    input  logic [L_CH_W-1:0]                  rd_chan,
    output logic [P_N_BINS-1:0][P_ADC_W-1:0]   rd_lim,
    output logic [P_N_BINS-1:0][P_OFF_W-1:0]   rd_off
);
    logic [P_ADC_W-1:0] lim_q [P_N_CHAN][P_N_BINS];
    logic [P_OFF_W-1:0] off_q [P_N_CHAN][P_N_BINS];

    // Table update: reset to pass-through, then single-entry writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < int'(P_N_CHAN); c++) begin
                for (int b = 0; b < int'(P_N_BINS); b++) begin
                    lim_q[c][b] <= '1;
                    off_q[c][b] <= '0;
                end
            end
        end else if (wr_en) begin
            if (wr_sel == CFG_OFFSET)
                off_q[wr_chan][wr_bin] <= wr_data[P_OFF_W-1:0];
            else
                lim_q[wr_chan][wr_bin] <= wr_data[P_ADC_W-1:0];
        end
    end

    // Read port: all bins of the requested channel.
    always_comb begin
        for (int b = 0; b < int'(P_N_BINS); b++) begin
            rd_lim[b] = lim_q[rd_chan][b];
            rd_off[b] = off_q[rd_chan][b];
        end
    end
endmodule

// File: rtl/slew_bin_search.sv
// Module: slew_bin_search
// Picks the lowest bin whose upper limit is at or above the amplitude. If
// no limit qualifies, picks the last bin. Purely combinational. Assumes the
// limits are non-decreasing in normal use, but the result stays well
// defined when they are not.
module slew_bin_search
    import slew_pkg::*;
#(
    parameter int unsigned P_ADC_W  = ADC_W,
    parameter int unsigned P_N_BINS = N_BINS,
    localparam int unsigned L_BIN_W = $clog2(P_N_BINS)
) (
    input  logic [P_ADC_W-1:0]                 adc,
    input  logic [P_N_BINS-1:0][P_ADC_W-1:0]   lims,
    output logic [L_BIN_W-1:0]                 bin
);
    logic found;

    // Priority encoder: the first bin whose limit covers the amplitude wins.
    always_comb begin
        bin   = L_BIN_W'(P_N_BINS - 1);
        found = 1'b0;
        for (int i = 0; i < int'(P_N_BINS); i++) begin
            if (!found && (adc <= lims[i])) begin
                bin   = L_BIN_W'(i);
                found = 1'b1;
            end
        end
    end

    // Checks that the chosen bin brackets the amplitude (R3, R4, R8).
    always_comb begin
        if (bin != L_BIN_W'(P_N_BINS - 1))
            assert_bin_upper_R3: assert (adc <= lims[bin]);
        if (bin != '0)
            assert_bin_lower_R4: assert (adc > lims[bin - L_BIN_W'(1)]);
    end
endmodule

// File: rtl/slew_add_sat.sv
// Module: slew_add_sat
// Adds a signed offset to an unsigned timing value and clamps the result
// to the unsigned range. When not enabled, it passes the timing value
// through. Purely combinational.
module slew_add_sat
    import slew_pkg::*;
#(
    parameter int unsigned P_TAC_W = TAC_W,
    parameter int unsigned P_OFF_W = OFF_W,
    localparam int unsigned L_SUM_W = ((P_TAC_W > P_OFF_W) ? P_TAC_W : P_OFF_W) + 2
) (
    input  logic               en,
    input  logic [P_TAC_W-1:0] tac,
    input  logic [P_OFF_W-1:0] off,
    output logic [P_TAC_W-1:0] res
);
    localparam logic signed [L_SUM_W-1:0] SAT_HI =
        {{(L_SUM_W-P_TAC_W){1'b0}}, {P_TAC_W{1'b1}}};

    logic signed [L_SUM_W-1:0] tac_ext;
    logic signed [L_SUM_W-1:0] off_ext;
    logic signed [L_SUM_W-1:0] sum;

    // Widened signed sum followed by clamping at both ends.
    always_comb begin
        tac_ext = {{(L_SUM_W-P_TAC_W){1'b0}}, tac};
        off_ext = {{(L_SUM_W-P_OFF_W){off[P_OFF_W-1]}}, off};
        sum     = tac_ext + off_ext;
        if (!en)
            res = tac;
        else if (sum[L_SUM_W-1])
            res = '0;
        else if (sum > SAT_HI)
            res = '1;
        else
            res = sum[P_TAC_W-1:0];
    end

    // A non-negative offset never lowers the value and a negative one never raises it (R6).
    always_comb begin
        if (en && !off[P_OFF_W-1])
            assert_no_drop_R6: assert (res >= tac);
        if (en && off[P_OFF_W-1])
            assert_no_rise_R6: assert (res <= tac);
    end
endmodule

// File: rtl/slew_corrector.sv
// Module: slew_corrector
// Top of the time-walk corrector. Stage 1 looks up the channel's limits,
// finds the bin and registers the selected offset. Stage 2 adds the offset
// and saturates. The channel tag and amplitude travel alongside. Assumes
// the incoming timing value has already had its pedestal removed.
module slew_corrector
    import slew_pkg::*;
#(
    parameter int unsigned P_ADC_W   = ADC_W,
    parameter int unsigned P_TAC_W   = TAC_W,
    parameter int unsigned P_OFF_W   = OFF_W,
    parameter int unsigned P_N_BINS  = N_BINS,
    parameter int unsigned P_N_CHAN  = N_CHAN,
    parameter int unsigned P_TIM_BIT = TIMING_BIT,
    localparam int unsigned L_BIN_W  = $clog2(P_N_BINS),
    localparam int unsigned L_CH_W   = $clog2(P_N_CHAN),
    localparam int unsigned L_CFG_W  = (P_ADC_W > P_OFF_W) ? P_ADC_W : P_OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [L_CH_W-1:0]   in_chan,
    input  logic [P_ADC_W-1:0]  in_adc,
    input  logic [P_TAC_W-1:0]  in_tac,
    input  logic                cfg_we,
    input  logic [L_CH_W-1:0]   cfg_chan,
    input  logic [L_BIN_W-1:0]  cfg_bin,
    input  logic                cfg_sel,
    input  logic [L_CFG_W-1:0]  cfg_data,
    output logic                out_valid,
    output logic [L_CH_W-1:0]   out_chan,
    output logic [P_ADC_W-1:0]  out_adc,
    output logic [P_TAC_W-1:0]  out_tac
);
    logic [P_N_BINS-1:0][P_ADC_W-1:0] ch_lim;
    logic [P_N_BINS-1:0][P_OFF_W-1:0] ch_off;
    logic [L_BIN_W-1:0]               bin_sel;

    logic               s1_valid;
    logic [L_CH_W-1:0]  s1_chan;
    logic [P_ADC_W-1:0] s1_adc;
    logic [P_TAC_W-1:0] s1_tac;
    logic [P_OFF_W-1:0] s1_off;
    logic               s1_apply;
    logic [P_TAC_W-1:0] s2_res;

    slew_cfg_store #(
        .P_ADC_W (P_ADC_W),
        .P_OFF_W (P_OFF_W),
        .P_N_BINS(P_N_BINS),
        .P_N_CHAN(P_N_CHAN)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_chan(cfg_chan),
        .wr_bin (cfg_bin),
        .wr_sel (cfg_sel),
        .wr_data(cfg_data),
        .rd_chan(in_chan),
        .rd_lim (ch_lim),
        .rd_off (ch_off)
    );

    slew_bin_search #(
        .P_ADC_W (P_ADC_W),
        .P_N_BINS(P_N_BINS)
    ) u_search (
        .adc (in_adc),
        .lims(ch_lim),
        .bin (bin_sel)
    );

    // Stage 1: capture the sample with its selected offset and timing-channel flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_chan  <= '0;
            s1_adc   <= '0;
            s1_tac   <= '0;
            s1_off   <= '0;
            s1_apply <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_chan  <= in_chan;
            s1_adc   <= in_adc;
            s1_tac   <= in_tac;
            s1_off   <= ch_off[bin_sel];
            s1_apply <= in_chan[P_TIM_BIT];
        end
    end

    slew_add_sat #(
        .P_TAC_W(P_TAC_W),
        .P_OFF_W(P_OFF_W)
    ) u_add (
        .en (s1_apply),
        .tac(s1_tac),
        .off(s1_off),
        .res(s2_res)
    );

    // Stage 2: register the corrected result for the mask stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_adc   <= '0;
            out_tac   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_chan  <= s1_chan;
            out_adc   <= s1_adc;
            out_tac   <= s2_res;
        end
    end

    // A strobed sample is delivered exactly two edges later (R2).
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // An empty cycle stays empty two edges later (R2).
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // Channel and amplitude arrive unchanged with their sample (R2).
    assert_tag_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_chan == $past(in_chan, 2) && out_adc == $past(in_adc, 2)));

    // Channels outside the timing group leave with their timing value intact (R5).
    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_chan[P_TIM_BIT]) |-> ##2 (out_tac == $past(in_tac, 2)));
endmodule

// File: tb/slew_corrector_tb.sv
// Bench for slew_corrector: drives on falling edges and checks each output
// against a two-deep shadow pipeline of values computed from a
// behavioural model of the limit and offset tables.
module slew_corrector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_chan = '0;
    logic [11:0] in_adc = '0;
    logic [11:0] in_tac = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_chan = '0;
    logic [2:0]  cfg_bin = '0;
    logic        cfg_sel = 1'b0;
    logic [11:0] cfg_data = '0;
    logic        out_valid;
    logic [4:0]  out_chan;
    logic [11:0] out_adc;
    logic [11:0] out_tac;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int lim_m [32][8];
    int off_m [32][8];

    bit    pv   [2];
    int    pch  [2];
    int    padc [2];
    int    ptac [2];
    string ptag [2];

    always #5 clk = ~clk;

    slew_corrector u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_chan(in_chan), .in_adc(in_adc), .in_tac(in_tac),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_bin(cfg_bin),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_adc(out_adc), .out_tac(out_tac)
    );

    function automatic int exp_tac(int ch, int adc, int tac);
        int b;
        int s;
        if (((ch >> 2) & 1) == 0) return tac;
        b = 7;
        for (int i = 7; i >= 0; i--) if (adc <= lim_m[ch][i]) b = i;
        s = tac + off_m[ch][b];
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    task automatic check_out();
        bit ok;
        total++;
        if (pv[1])
            ok = out_valid && (int'(out_chan) == pch[1]) && (int'(out_adc) == padc[1])
                 && (int'(out_tac) == ptac[1]);
        else
            ok = !out_valid;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got v=%0b ch=%0d adc=%0d tac=%0d exp v=%0b ch=%0d adc=%0d tac=%0d",
                     ptag[1], out_valid, out_chan, out_adc, out_tac,
                     pv[1], pch[1], padc[1], ptac[1]);
        end
    endtask

    // One cycle: check the output due now, then drive a sample and/or a write.
    task automatic step(input bit v, input int ch, input int adc, input int tac, input string tag,
                        input bit w = 0, input int wch = 0, input int wbin = 0,
                        input int wsel = 0, input int wdata = 0);
        @(negedge clk);
        check_out();
        pv[1] = pv[0]; pch[1] = pch[0]; padc[1] = padc[0]; ptac[1] = ptac[0]; ptag[1] = ptag[0];
        pv[0] = v; pch[0] = ch; padc[0] = adc; ptac[0] = exp_tac(ch, adc, tac); ptag[0] = tag;
        in_valid = v;
        in_chan  = ch[4:0];
        in_adc   = adc[11:0];
        in_tac   = tac[11:0];
        cfg_we   = w;
        cfg_chan = wch[4:0];
        cfg_bin  = wbin[2:0];
        cfg_sel  = wsel[0];
        cfg_data = wdata[11:0];
        if (w) begin
            if (wsel == 1) off_m[wch][wbin] = wdata;
            else           lim_m[wch][wbin] = wdata;
        end
    endtask

    task automatic wr(input int ch, input int bin, input int sel, input int data, input string tag);
        step(0, 0, 0, 0, tag, 1, ch, bin, sel, data);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
    endtask

    initial begin
        int lims_a [8] = '{30, 60, 95, 135, 200, 300, 600, 4095};
        int offs_a [8] = '{121, 71, 38, 19, 3, -12, -30, -101};
        int lims_t [8] = '{50, 50, 50, 100, 100, 4095, 4095, 4095};
        for (int c = 0; c < 32; c++)
            for (int b = 0; b < 8; b++) begin
                lim_m[c][b] = 4095;
                off_m[c][b] = 0;
            end
        for (int i = 0; i < 2; i++) begin
            pv[i] = 0; pch[i] = 0; padc[i] = 0; ptac[i] = 0; ptag[i] = "R1";
        end

        // R1: no output strobe while held in reset.
        idle(4, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R1: every channel is a pass-through after reset.
        for (int c = 0; c < 32; c++) step(1, c, (c * 131) % 4096, (c * 97 + 5) % 4096, "R1");
        idle(2, "R1");

        // R5: same offset on all bins of every channel; only timing channels move.
        for (int c = 0; c < 32; c++)
            for (int b = 0; b < 8; b++) wr(c, b, 1, 40, "R5");
        for (int c = 0; c < 32; c++) step(1, c, (c * 53) % 4096, 2000 + c, "R5");
        for (int c = 0; c < 32; c++) step(1, c, 0, 4080, "R5");

        // R7/R3: load a full limit and offset set into ch5 and non-timing ch2.
        for (int b = 0; b < 8; b++) begin
            wr(5, b, 0, lims_a[b], "R7");
            wr(5, b, 1, offs_a[b], "R7");
            wr(2, b, 0, lims_a[b], "R7");
            wr(2, b, 1, offs_a[b], "R7");
        end
        // R3: exhaustive amplitude sweep on a timing channel.
        for (int a = 0; a < 4096; a++) step(1, 5, a, 2000, "R3");
        // R5: the stored table of a non-timing channel has no effect.
        for (int a = 0; a < 4096; a += 7) step(1, 2, a, 1000, "R5");
        // R2: alternating gaps, varying channels.
        for (int i = 0; i < 64; i++) step(i % 3 != 1, i % 32, (i * 61) % 4096, (i * 67) % 4096, "R2");

        // R6: extreme offsets, saturation at both ends.
        wr(5, 0, 1, 255, "R6");
        wr(5, 7, 1, -256, "R6");
        for (int t = 0; t < 4096; t += 3) begin
            step(1, 5, 10, t, "R6");
            step(1, 5, 4000, t, "R6");
        end
        step(1, 5, 10, 3840, "R6");
        step(1, 5, 10, 3841, "R6");
        step(1, 5, 4000, 256, "R6");
        step(1, 5, 4000, 255, "R6");

        // R4: equal limits, lowest bin wins.
        for (int b = 0; b < 8; b++) begin
            wr(13, b, 0, lims_t[b], "R4");
            wr(13, b, 1, b + 1, "R4");
        end
        for (int a = 0; a <= 200; a++) step(1, 13, a, 500, "R4");

        // R8: amplitudes above every limit fall into the last bin.
        for (int b = 0; b < 8; b++) begin
            wr(14, b, 0, 1000, "R8");
            wr(14, b, 1, (b == 7) ? 77 : 0, "R8");
        end
        for (int a = 990; a < 4096; a += 5) step(1, 14, a, 1234, "R8");
        step(1, 14, 4095, 1234, "R8");

        // R7: a write lands one cycle later; a same-cycle sample sees the old value.
        step(1, 21, 0, 500, "R7", 1, 21, 0, 1, 50);
        step(1, 21, 0, 500, "R7");
        step(1, 21, 0, 500, "R7", 1, 21, 0, 0, 0);
        step(1, 21, 1, 500, "R7");
        step(1, 21, 0, 500, "R7");

        idle(3, "R2");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R2: watchdog expired, got no end exp end of test");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule